// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block holds a queue of compute kernels whose launches are outstanding and feeds their workgroups, one at a time, to a placement agent in front of the compute units. Each launch brings a kernel identifier, the number of workgroups the kernel contains and an acquire flag. Kernel identifiers wait in a first-in first-out queue. Per-kernel state (workgroup total, workgroups sent, invalidate progress) sits in a table indexed by the identifier.

Work proceeds in passes. A pass begins after an accepted launch, after a kernel's invalidate counter drains, or after the compute units report freed resources. In each pass the scheduler looks at the queue head over and over. If a kernel is still waiting on its cache invalidate, or if the placement agent refuses one of its workgroups, that kernel moves to the tail and counts as one failure for the pass. A kernel whose workgroups have all been sent leaves the queue. The pass ends as soon as the number of failures reaches the queue occupancy. A kernel stuck on large workgroups therefore does not hold back kernels that fit. Three counters report accepted launches, passes that found work, and kernels that placed their first workgroup within a pass.

The cache and the compute units are outside the block. The cache reports its invalidate traffic as single-step increment and decrement events for each kernel.

Top module: `kd_dispatch_sched`

## Requirements
- R1: After synchronous reset, launch_ready is 1, place_valid and inv_start_valid are 0, and all three statistic counters read 0.
- R2: With every placement granted, kernels have their workgroups issued in the order their launches were accepted.
- R3: Once a kernel's invalidate is complete, place_valid stays high with place_kid naming it. A request that is neither granted nor denied holds unchanged. Each grant consumes one workgroup. A kernel launched with total N receives exactly N grants, then leaves the queue and is never offered again.
- R4: A denied placement drops place_valid on the next cycle and moves the kernel to the queue tail, counting one failure. Later kernels in the same pass are still examined, so they can overtake it.
- R5: A pass keeps examining the head while occupancy exceeds the failures counted in that pass, and the failure count clears when a pass begins. A pass is triggered by an accepted launch, by an invalidate drain, or by a cu_free pulse.
- R6: For a kernel launched with acquire=1, the first examination emits a one-cycle inv_start_valid pulse with inv_start_kid set to that kernel. The kernel is then held with no placement until its invalidate counter, raised by at least one increment, is decremented back to zero. A kernel launched with acquire=0 emits no pulse and is placeable at once.
- R7: An invalidate event adds one when inv_evt_inc=1 and subtracts one when inv_evt_inc=0. A decrement at a count of zero is ignored: it neither completes the invalidate nor starts a pass. A decrement that reaches zero starts a pass on the following clock.
- R8: stat_launch_cnt counts accepted launches. stat_wait_cnt counts passes that begin with a non-empty queue, so a pass over an empty queue is not counted. stat_start_cnt adds one per kernel per pass on that kernel's first granted workgroup, and a denial adds nothing.
- R9: launch_ready is 0 while a pass is in progress and while the queue holds NUM_KERN kernels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Launch request can be accepted |
| launch_kid | input | ID_W | Identifier of the launched kernel |
| launch_wg_total | input | WG_W | Workgroup count of the kernel (at least 1) |
| launch_acquire | input | 1 | Cache invalidate required before dispatch |
| inv_start_valid | output | 1 | One-cycle request to start an invalidate |
| inv_start_kid | output | ID_W | Kernel the invalidate belongs to |
| inv_evt_valid | input | 1 | Invalidate counter event |
| inv_evt_kid | input | ID_W | Kernel of the counter event |
| inv_evt_inc | input | 1 | 1 = add one, 0 = subtract one |
| cu_free | input | 1 | Compute-unit resources freed; starts a pass |
| place_valid | output | 1 | Workgroup placement request |
| place_kid | output | ID_W | Kernel whose next workgroup is offered |
| place_grant | input | 1 | Placement accepted this cycle |
| place_deny | input | 1 | Placement refused this cycle |
| stat_launch_cnt | output | STAT_W | Accepted launch count |
| stat_wait_cnt | output | STAT_W | Passes begun with work queued |
| stat_start_cnt | output | STAT_W | Per-pass first-placement count |

## Verification
A lone kernel with every placement granted shows the basic workgroup count and the removal of a finished kernel. A pattern that refuses one kernel while later ones are granted separates rotate-and-continue from stop-at-first-failure. An acquire kernel fed a stray decrement, then increments and decrements, tells the real drain condition apart from a bare zero count. Eight refused launches that fill the queue, released by a resource pulse, show back-pressure and show that repeated full rotations keep the order.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_EXAM  = 2'd1,
    PS_PLACE = 2'd2
  } pass_state_e;
endpackage

// File: rtl/kd_id_fifo.sv
module kd_id_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CNT_W'(1);
      else if (pop && !push) count <= count - CNT_W'(1);
    end
  end

  assign head = mem[rd_ptr];
  assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/kd_kernel_table.sv
module kd_kernel_table #(
  parameter int NUM_KERN = 8,
  parameter int ID_W     = 3,
  parameter int WG_W     = 16,
  parameter int INV_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [ID_W-1:0] ld_id,
  input  logic [WG_W-1:0] ld_total,
  input  logic            ld_acq,
  input  logic            mark_en,
  input  logic [ID_W-1:0] mark_id,
  input  logic            evt_en,
  input  logic [ID_W-1:0] evt_id,
  input  logic            evt_inc,
  input  logic            sent_en,
  input  logic [ID_W-1:0] sent_id,
  input  logic [ID_W-1:0] rd_id,
  output logic [WG_W-1:0] rd_total,
  output logic [WG_W-1:0] rd_sent,
  output logic            rd_acq,
  output logic            rd_started,
  output logic            rd_done,
  output logic            drain
);
  logic [NUM_KERN-1:0][WG_W-1:0]  total_v, sent_v;
  logic [NUM_KERN-1:0][INV_W-1:0] cnt_v;
  logic [NUM_KERN-1:0]            acq_v, started_v, done_v;

  for (genvar k = 0; k < NUM_KERN; k++) begin : g_entry
    logic [WG_W-1:0]  total_q, sent_q;
    logic [INV_W-1:0] cnt_q;
    logic             acq_q, started_q, done_q;
    logic             hit_ld, hit_mark, hit_evt, hit_sent;

    assign hit_ld   = ld_en   && (ld_id   == ID_W'(k));
    assign hit_mark = mark_en && (mark_id == ID_W'(k));
    assign hit_evt  = evt_en  && (evt_id  == ID_W'(k));
    assign hit_sent = sent_en && (sent_id == ID_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        total_q   <= '0;
        sent_q    <= '0;
        cnt_q     <= '0;
        acq_q     <= 1'b0;
        started_q <= 1'b0;
        done_q    <= 1'b0;
      end else if (hit_ld) begin
        total_q   <= ld_total;
        sent_q    <= '0;
        cnt_q     <= '0;
        acq_q     <= ld_acq;
        started_q <= 1'b0;
        done_q    <= !ld_acq;
      end else begin
        if (hit_mark) started_q <= 1'b1;
        if (hit_sent) sent_q <= sent_q + WG_W'(1);
        if (hit_evt) begin
          if (evt_inc) begin
            if (cnt_q != {INV_W{1'b1}}) cnt_q <= cnt_q + INV_W'(1);
          end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - INV_W'(1);
            if (cnt_q == INV_W'(1)) done_q <= 1'b1;
          end
        end
      end
    end

    assign total_v[k]   = total_q;
    assign sent_v[k]    = sent_q;
    assign cnt_v[k]     = cnt_q;
    assign acq_v[k]     = acq_q;
    assign started_v[k] = started_q;
    assign done_v[k]    = done_q;
  end

  assign rd_total   = total_v[rd_id];
  assign rd_sent    = sent_v[rd_id];
  assign rd_acq     = acq_v[rd_id];
  assign rd_started = started_v[rd_id];
  assign rd_done    = done_v[rd_id];
  assign drain      = evt_en && !evt_inc && (cnt_v[evt_id] == INV_W'(1));
endmodule

// File: rtl/kd_pass_ctrl.sv
module kd_pass_ctrl
  import kd_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 3,
  parameter int WG_W   = 16,
  parameter int STAT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       launch_fire,
  input  logic                       drain,
  input  logic                       cu_free,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  input  logic [ID_W-1:0]            head_id,
  input  logic [WG_W-1:0]            head_total,
  input  logic [WG_W-1:0]            head_sent,
  input  logic                       head_acq,
  input  logic                       head_started,
  input  logic                       head_done,
  input  logic                       grant,
  input  logic                       deny,
  output logic                       idle,
  output logic                       rotate,
  output logic                       pop_done,
  output logic                       mark_en,
  output logic                       sent_en,
  output logic                       place_valid,
  output logic [ID_W-1:0]            place_kid,
  output logic                       inv_start_valid,
  output logic [ID_W-1:0]            inv_start_kid,
  output logic [STAT_W-1:0]          stat_launch_cnt,
  output logic [STAT_W-1:0]          stat_wait_cnt,
  output logic [STAT_W-1:0]          stat_start_cnt
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  pass_state_e      state;
  logic [CNT_W-1:0] fail_cnt;
  logic             pending, launched_q;
  logic             examine, in_exam, in_place, last_wg;

  assign idle     = (state == PS_IDLE);
  assign in_exam  = (state == PS_EXAM);
  assign in_place = (state == PS_PLACE);
  assign examine  = in_exam && (occ > fail_cnt);
  assign last_wg  = (head_sent + WG_W'(1)) == head_total;

  assign mark_en  = examine && head_acq && !head_started;
  assign sent_en  = in_place && grant;
  assign pop_done = in_place && grant && last_wg;
  assign rotate   = (examine && !head_done) || (in_place && !grant && deny);

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= PS_IDLE;
      fail_cnt        <= '0;
      pending         <= 1'b0;
      launched_q      <= 1'b0;
      place_valid     <= 1'b0;
      place_kid       <= '0;
      inv_start_valid <= 1'b0;
      inv_start_kid   <= '0;
      stat_launch_cnt <= '0;
      stat_wait_cnt   <= '0;
      stat_start_cnt  <= '0;
    end else begin
      inv_start_valid <= mark_en;
      if (mark_en) inv_start_kid <= head_id;
      if (launch_fire) stat_launch_cnt <= stat_launch_cnt + STAT_W'(1);
      if (rotate) fail_cnt <= fail_cnt + CNT_W'(1);

      // trigger events collected while busy run one more pass later
      if (launch_fire || drain || cu_free) pending <= 1'b1;
      else if (idle && pending)            pending <= 1'b0;

      unique case (state)
        PS_IDLE: begin
          if (pending) begin
            fail_cnt <= '0;
            if (occ != '0) stat_wait_cnt <= stat_wait_cnt + STAT_W'(1);
            state <= PS_EXAM;
          end
        end
        PS_EXAM: begin
          if (!examine) begin
            state <= PS_IDLE;
          end else if (head_done) begin
            state       <= PS_PLACE;
            place_valid <= 1'b1;
            place_kid   <= head_id;
            launched_q  <= 1'b0;
          end
        end
        PS_PLACE: begin
          if (grant) begin
            if (!launched_q) stat_start_cnt <= stat_start_cnt + STAT_W'(1);
            launched_q <= 1'b1;
            if (last_wg) begin
              place_valid <= 1'b0;
              state       <= PS_EXAM;
            end
          end else if (deny) begin
            place_valid <= 1'b0;
            state       <= PS_EXAM;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kd_dispatch_sched.sv
module kd_dispatch_sched #(
  parameter int NUM_KERN = 8,
  parameter int ID_W     = $clog2(NUM_KERN),
  parameter int WG_W     = 16,
  parameter int INV_W    = 8,
  parameter int STAT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_valid,
  output logic              launch_ready,
  input  logic [ID_W-1:0]   launch_kid,
  input  logic [WG_W-1:0]   launch_wg_total,
  input  logic              launch_acquire,
  output logic              inv_start_valid,
  output logic [ID_W-1:0]   inv_start_kid,
  input  logic              inv_evt_valid,
  input  logic [ID_W-1:0]   inv_evt_kid,
  input  logic              inv_evt_inc,
  input  logic              cu_free,
  output logic              place_valid,
  output logic [ID_W-1:0]   place_kid,
  input  logic              place_grant,
  input  logic              place_deny,
  output logic [STAT_W-1:0] stat_launch_cnt,
  output logic [STAT_W-1:0] stat_wait_cnt,
  output logic [STAT_W-1:0] stat_start_cnt
);
  localparam int CNT_W = $clog2(NUM_KERN + 1);

  logic             launch_fire, idle, rotate, pop_done, mark_en, sent_en, drain;
  logic             fifo_full, fifo_push, fifo_pop;
  logic [ID_W-1:0]  head_id, push_id;
  logic [CNT_W-1:0] fifo_count;
  logic [WG_W-1:0]  head_total, head_sent;
  logic             head_acq, head_started, head_done;

  assign launch_ready = idle && !fifo_full;
  assign launch_fire  = launch_valid && launch_ready;
  assign fifo_push    = launch_fire || rotate;
  assign fifo_pop     = rotate || pop_done;
  assign push_id      = rotate ? head_id : launch_kid;

  kd_id_fifo #(.DEPTH(NUM_KERN), .W(ID_W)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .push_data(push_id), .pop(fifo_pop),
    .head(head_id), .count(fifo_count), .full(fifo_full)
  );

  kd_kernel_table #(.NUM_KERN(NUM_KERN), .ID_W(ID_W), .WG_W(WG_W), .INV_W(INV_W)) u_table (
    .clk(clk), .rst(rst),
    .ld_en(launch_fire), .ld_id(launch_kid), .ld_total(launch_wg_total), .ld_acq(launch_acquire),
    .mark_en(mark_en), .mark_id(head_id),
    .evt_en(inv_evt_valid), .evt_id(inv_evt_kid), .evt_inc(inv_evt_inc),
    .sent_en(sent_en), .sent_id(head_id),
    .rd_id(head_id), .rd_total(head_total), .rd_sent(head_sent), .rd_acq(head_acq),
    .rd_started(head_started), .rd_done(head_done), .drain(drain)
  );

  kd_pass_ctrl #(.DEPTH(NUM_KERN), .ID_W(ID_W), .WG_W(WG_W), .STAT_W(STAT_W)) u_ctrl (
    .clk(clk), .rst(rst), .launch_fire(launch_fire), .drain(drain), .cu_free(cu_free),
    .occ(fifo_count), .head_id(head_id), .head_total(head_total), .head_sent(head_sent),
    .head_acq(head_acq), .head_started(head_started), .head_done(head_done),
    .grant(place_grant), .deny(place_deny),
    .idle(idle), .rotate(rotate), .pop_done(pop_done), .mark_en(mark_en), .sent_en(sent_en),
    .place_valid(place_valid), .place_kid(place_kid),
    .inv_start_valid(inv_start_valid), .inv_start_kid(inv_start_kid),
    .stat_launch_cnt(stat_launch_cnt), .stat_wait_cnt(stat_wait_cnt),
    .stat_start_cnt(stat_start_cnt)
  );
endmodule

// File: rtl/kd_dispatch_sched_chk.sv
module kd_dispatch_sched_chk #(
  parameter int NUM_KERN = 8,
  parameter int ID_W     = 3,
  parameter int STAT_W   = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         launch_valid,
  input logic                         launch_ready,
  input logic                         place_valid,
  input logic [ID_W-1:0]              place_kid,
  input logic                         place_grant,
  input logic                         place_deny,
  input logic [STAT_W-1:0]            stat_launch_cnt,
  input logic [STAT_W-1:0]            stat_wait_cnt,
  input logic [$clog2(NUM_KERN+1)-1:0] fifo_count
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!place_valid && stat_launch_cnt == '0 && stat_wait_cnt == '0));

  p_hold_request_r3: assert property (@(posedge clk) disable iff (rst)
    (place_valid && !place_grant && !place_deny) |=> (place_valid && $stable(place_kid)));

  p_deny_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (place_valid && place_deny && !place_grant) |=> !place_valid);

  p_launch_stat_r8: assert property (@(posedge clk) disable iff (rst)
    (launch_valid && launch_ready) |=> (stat_launch_cnt == $past(stat_launch_cnt) + STAT_W'(1)));

  p_wait_step_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_wait_cnt - $past(stat_wait_cnt)) <= STAT_W'(1));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= ($clog2(NUM_KERN+1))'(NUM_KERN));
endmodule

bind kd_dispatch_sched kd_dispatch_sched_chk #(
  .NUM_KERN(NUM_KERN), .ID_W(ID_W), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst(rst), .launch_valid(launch_valid), .launch_ready(launch_ready),
  .place_valid(place_valid), .place_kid(place_kid), .place_grant(place_grant),
  .place_deny(place_deny), .stat_launch_cnt(stat_launch_cnt),
  .stat_wait_cnt(stat_wait_cnt), .fifo_count(fifo_count)
);

// File: tb/kd_dispatch_sched_tb.sv
module kd_dispatch_sched_tb;
  localparam int NK = 8;
  localparam int IW = 3;
  localparam int WW = 16;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic          launch_valid = 1'b0, launch_acquire = 1'b0;
  logic          launch_ready;
  logic [IW-1:0] launch_kid = '0;
  logic [WW-1:0] launch_wg_total = '0;
  logic          inv_start_valid;
  logic [IW-1:0] inv_start_kid;
  logic          inv_evt_valid = 1'b0, inv_evt_inc = 1'b0, cu_free = 1'b0;
  logic [IW-1:0] inv_evt_kid = '0;
  logic          place_valid, place_grant, place_deny;
  logic [IW-1:0] place_kid;
  logic [SW-1:0] stat_launch_cnt, stat_wait_cnt, stat_start_cnt;

  logic          deny_all = 1'b0, deny_one = 1'b0;
  logic [IW-1:0] deny_kid = '0;
  logic          deny_now;
  assign deny_now    = deny_all || (deny_one && place_kid == deny_kid);
  assign place_grant = place_valid && !deny_now;
  assign place_deny  = place_valid && deny_now;

  kd_dispatch_sched #(.NUM_KERN(NK), .ID_W(IW), .WG_W(WW), .STAT_W(SW)) u_dut (.*);

  int checks = 0, errors = 0;
  int inv_seen = 0;
  logic [IW-1:0] inv_last = '0;
  int exp_q[$];
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare granted placements against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && place_valid && place_grant) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected placement", int'(place_kid), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(place_kid) == e, "R2/R3 placement order", int'(place_kid), e);
      end
    end
    if (!rst && inv_start_valid) begin
      inv_seen++;
      inv_last = inv_start_kid;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wg(input int kid, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(kid);
  endtask

  task automatic launch(input int kid, input int total, input bit acq);
    while (!launch_ready) tick();
    launch_valid = 1'b1; launch_kid = IW'(kid);
    launch_wg_total = WW'(total); launch_acquire = acq;
    tick();
    launch_valid = 1'b0;
  endtask

  task automatic free_pulse();
    cu_free = 1'b1; tick(); cu_free = 1'b0;
  endtask

  task automatic inv_evt(input int kid, input bit inc);
    inv_evt_valid = 1'b1; inv_evt_kid = IW'(kid); inv_evt_inc = inc;
    tick();
    inv_evt_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    int w0, s0, l0, hold_bad;
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    check(launch_ready == 1'b1, "R1 launch_ready", launch_ready, 1);
    check(place_valid == 1'b0 && inv_start_valid == 1'b0, "R1 outputs idle", place_valid, 0);
    check(stat_launch_cnt == 0 && stat_wait_cnt == 0 && stat_start_cnt == 0,
          "R1 stats zero", int'(stat_wait_cnt), 0);

    // single kernel, all grants: R3, R9 busy, R8 empty pass
    w0 = stat_wait_cnt; s0 = stat_start_cnt; l0 = stat_launch_cnt;
    expect_wg(1, 3);
    launch(1, 3, 1'b0);
    tick();
    check(launch_ready == 1'b0, "R9 busy during pass", launch_ready, 0);
    tick(20);
    free_pulse();  // empty queue: pass not counted, kernel gone
    tick(10);
    check(exp_q.size() == 0, "R3 all workgroups sent", exp_q.size(), 0);
    check(int'(stat_wait_cnt) - w0 == 1, "R8 wait count single", int'(stat_wait_cnt) - w0, 1);
    check(int'(stat_start_cnt) - s0 == 1, "R8 start count single", int'(stat_start_cnt) - s0, 1);
    check(int'(stat_launch_cnt) - l0 == 1, "R8 launch count", int'(stat_launch_cnt) - l0, 1);
    check(inv_seen == 0, "R6 no invalidate without acquire", inv_seen, 0);

    // overtake: kernel 2 refused, kernel 5 proceeds (R4, R5)
    w0 = stat_wait_cnt; s0 = stat_start_cnt;
    deny_one = 1'b1; deny_kid = 3'd2;
    launch(2, 2, 1'b0);
    tick(20);
    expect_wg(5, 2);
    launch(5, 2, 1'b0);
    tick(20);
    check(exp_q.size() == 0, "R4 later kernel overtakes", exp_q.size(), 0);
    check(int'(stat_start_cnt) - s0 == 1, "R8 denial not counted", int'(stat_start_cnt) - s0, 1);
    deny_one = 1'b0;
    expect_wg(2, 2);
    free_pulse();
    tick(20);
    check(exp_q.size() == 0, "R5 cu_free starts retry pass", exp_q.size(), 0);
    check(int'(stat_wait_cnt) - w0 == 3, "R8 wait count rotate", int'(stat_wait_cnt) - w0, 3);
    check(int'(stat_start_cnt) - s0 == 2, "R8 start count rotate", int'(stat_start_cnt) - s0, 2);

    // acquire: R6, R7
    w0 = stat_wait_cnt;
    launch(6, 1, 1'b1);
    tick(10);
    check(inv_seen == 1 && inv_last == 3'd6, "R6 invalidate start pulse", inv_seen, 1);
    hold_bad = 0;
    inv_evt(6, 1'b0);  // decrement at zero: ignored
    for (int i = 0; i < 10; i++) begin tick(); if (place_valid) hold_bad++; end
    check(int'(stat_wait_cnt) - w0 == 1, "R7 stray decrement no pass", int'(stat_wait_cnt) - w0, 1);
    inv_evt(6, 1'b1); inv_evt(6, 1'b1); inv_evt(6, 1'b0);
    for (int i = 0; i < 10; i++) begin tick(); if (place_valid) hold_bad++; end
    check(hold_bad == 0, "R6 held until drain", hold_bad, 0);
    expect_wg(6, 1);
    inv_evt(6, 1'b0);
    tick(15);
    check(exp_q.size() == 0, "R7 drain releases kernel", exp_q.size(), 0);
    check(int'(stat_wait_cnt) - w0 == 2, "R7 drain starts pass", int'(stat_wait_cnt) - w0, 2);
    check(inv_seen == 1, "R6 single invalidate start", inv_seen, 1);

    // fill queue with refused kernels: R9 back-pressure, R2 order
    w0 = stat_wait_cnt; s0 = stat_start_cnt;
    deny_all = 1'b1;
    for (int k = 0; k < NK; k++) begin
      launch(k, 1, 1'b0);
      tick(40);
      if (k == NK - 2) check(launch_ready == 1'b1, "R9 ready below full", launch_ready, 1);
    end
    check(launch_ready == 1'b0, "R9 full queue stalls launch", launch_ready, 0);
    deny_all = 1'b0;
    for (int k = 0; k < NK; k++) expect_wg(k, 1);
    free_pulse();
    tick(40);
    check(exp_q.size() == 0, "R2 launch order kept", exp_q.size(), 0);
    check(launch_ready == 1'b1, "R9 ready after drain", launch_ready, 1);
    check(int'(stat_wait_cnt) - w0 == NK + 1, "R8 wait count full", int'(stat_wait_cnt) - w0, NK + 1);
    check(int'(stat_start_cnt) - s0 == NK, "R8 start count full", int'(stat_start_cnt) - s0, NK);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule